// File: doc/BRIEF.md
# Parallel-Translation Cache Tag Lookup

This block does the lookup for a small first-level data cache. The set is chosen by bits of the virtual address that sit inside the page offset. Those bits are the same before and after translation, so the tag and data arrays are read in the same cycle that a small fully associative translation buffer maps the virtual page number to a physical page number. Each way stores a physical page number as its tag. A way hits when its line is valid and its stored tag equals the translated page number. The block then returns the way number and the addressed word of that line.

Tags are physical, so a change of address space needs no flush and no space identifier. Two virtual pages that map to the same physical page find the same line. The translation buffer and the line arrays are written through their own fill ports, one entry per cycle. The response is registered, and a new request can be accepted on every clock.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, no response is valid and every translation entry and every cache line is invalid. A lookup therefore reports a translation miss until a translation is loaded, and a cache miss until a line is loaded.
- R2: A request presented in one cycle gets a response with `rsp_valid` high in the next cycle. A request is accepted on every cycle, and a cycle with no request produces `rsp_valid` low in the following cycle.
- R3: When no valid translation entry matches the virtual page number (`req_va[31:12]`), the response raises `rsp_tlb_miss` and keeps `rsp_hit` and `rsp_miss` low.
- R4: When the translation hits and a valid line in set `req_va[11:6]` holds a tag equal to the translated physical page number, the response raises `rsp_hit`. `rsp_way` gives that way, and `rsp_data` returns word `req_va[5:2]` of the line, where word k occupies line bits `[32k+31:32k]`.
- R5: When the translation hits but no valid line in the set carries the matching tag, the response raises `rsp_miss` only.
- R6: The set index is taken only from page-offset bits. Two different virtual pages that map to one physical page hit the same line with the same data.
- R7: A translation fill writes the virtual and physical page numbers into the slot it names and marks that slot valid. A later fill to the same slot replaces the old mapping, so the old virtual page then reports a translation miss.
- R8: A line fill writes the tag and line data into the named way and set and marks the line valid. The other way of that set is left unchanged, and a refill replaces the old tag.
- R9: A lookup in the same cycle as a line fill or a translation fill sees the contents as they were before that fill.
- R10: When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_tlb_miss` is high. When `rsp_valid` is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual byte address of the request |
| tlb_fill_valid | input | 1 | Write a translation entry |
| tlb_fill_slot | input | 2 | Translation slot to write |
| tlb_fill_vpn | input | 20 | Virtual page number for the slot |
| tlb_fill_ppn | input | 20 | Physical page number for the slot |
| line_fill_valid | input | 1 | Write a cache line |
| line_fill_way | input | 1 | Way to write |
| line_fill_set | input | 6 | Set to write |
| line_fill_tag | input | 20 | Physical tag of the line |
| line_fill_data | input | 512 | Line contents |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Cache hit |
| rsp_miss | output | 1 | Translation hit, cache miss |
| rsp_tlb_miss | output | 1 | No translation for the page |
| rsp_way | output | 1 | Way that hit |
| rsp_data | output | 32 | Addressed word on a hit, zero otherwise |

## Verification
The bench fills both ways of all 64 sets with distinct tags and contents, then sweeps every set under each translation slot with back-to-back requests. A wrong index slice or a wrong word select shows up there as wrong data, and a wrong tag compare shows up as the wrong way. An aliased virtual page is checked against the same lines, which catches any use of translated bits in the index. Fills issued in the same cycle as a lookup check the read-before-write ordering: a design that forwards the fill would report a hit one cycle early. A refill of one way and a replaced translation slot check that stale tags and stale mappings no longer match, and that the neighbouring way keeps its contents.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Outcome of one lookup, resolved before registering the response.
    typedef enum logic [1:0] {
        OUT_NONE    = 2'd0,
        OUT_HIT     = 2'd1,
        OUT_MISS    = 2'd2,
        OUT_TLBMISS = 2'd3
    } outcome_e;

    // Width of an index over n items, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int SLOT_W = vipt_pkg::idx_width(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_we,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn
);

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [VPN_W-1:0]   vpn_d [ENTRIES];
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_d [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    // Associative match, lowest slot wins if several match.
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && (vpn_q[i] == lk_vpn)) begin
                lk_hit = 1'b1;
                lk_ppn = ppn_q[i];
            end
        end
    end

    // Next state: one slot written per fill.
    always_comb begin
        valid_d = valid_q;
        vpn_d   = vpn_q;
        ppn_d   = ppn_q;
        if (fill_we) begin
            valid_d[fill_slot] = 1'b1;
            vpn_d[fill_slot]   = fill_vpn;
            ppn_d[fill_slot]   = fill_ppn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        vpn_q <= vpn_d;
        ppn_q <= ppn_d;
    end

    // R7: a filled slot is valid afterwards.
    a_r7_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> valid_q[$past(fill_slot)]);

endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int SETS   = 64,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 512,
    localparam int IDX_W = vipt_pkg::idx_width(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);

    logic [SETS-1:0]   valid_d, valid_q;
    logic [TAG_W-1:0]  tag_d  [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_d [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Read of the current contents; a fill this cycle lands after the edge.
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        line_d  = line_q;
        if (fill_we) begin
            valid_d[fill_idx] = 1'b1;
            tag_d[fill_idx]   = fill_tag;
            line_d[fill_idx]  = fill_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        line_q <= line_d;
    end

    // R8: a filled line is valid and carries the new tag afterwards.
    a_r8_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> valid_q[$past(fill_idx)]);
    a_r8_fill_writes_tag: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_W     = 12,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 2,
    parameter int TLB_N      = 4,
    parameter int WORD_W     = 32,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = PAGE_W - OFS_W,
    localparam int SETS      = 1 << IDX_W,
    localparam int VPN_W     = VA_W - PAGE_W,
    localparam int PPN_W     = PA_W - PAGE_W,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORDS     = LINE_W / WORD_W,
    localparam int WSEL_W    = vipt_pkg::idx_width(WORDS),
    localparam int BOFS_W    = $clog2(WORD_W / 8),
    localparam int WAY_W     = vipt_pkg::idx_width(WAYS),
    localparam int SLOT_W    = vipt_pkg::idx_width(TLB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              tlb_fill_valid,
    input  logic [SLOT_W-1:0] tlb_fill_slot,
    input  logic [VPN_W-1:0]  tlb_fill_vpn,
    input  logic [PPN_W-1:0]  tlb_fill_ppn,
    input  logic              line_fill_valid,
    input  logic [WAY_W-1:0]  line_fill_way,
    input  logic [IDX_W-1:0]  line_fill_set,
    input  logic [PPN_W-1:0]  line_fill_tag,
    input  logic [LINE_W-1:0] line_fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_tlb_miss,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [WORD_W-1:0] rsp_data
);
    import vipt_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic              tlbm;
        logic [WAY_W-1:0]  way;
        logic [WORD_W-1:0] data;
    } rsp_t;

    // Address fields: index and word select lie wholly inside the page offset.
    logic [VPN_W-1:0]  va_vpn;
    logic [IDX_W-1:0]  va_idx;
    logic [WSEL_W-1:0] va_wsel;
    logic              unused_byte_ofs;

    assign va_vpn          = req_va[VA_W-1:PAGE_W];
    assign va_idx          = req_va[PAGE_W-1:OFS_W];
    assign va_wsel         = req_va[OFS_W-1:BOFS_W];
    assign unused_byte_ofs = ^req_va[BOFS_W-1:0];

    // Translation, in parallel with the array read.
    logic             tlb_hit;
    logic [PPN_W-1:0] tlb_ppn;

    vipt_tlb #(
        .ENTRIES (TLB_N),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (va_vpn),
        .lk_hit    (tlb_hit),
        .lk_ppn    (tlb_ppn),
        .fill_we   (tlb_fill_valid),
        .fill_slot (tlb_fill_slot),
        .fill_vpn  (tlb_fill_vpn),
        .fill_ppn  (tlb_fill_ppn)
    );

    // Ways, each read with the untranslated index.
    logic [WAYS-1:0]   way_hit;
    logic [WAYS-1:0]   rd_valid;
    logic [PPN_W-1:0]  rd_tag  [WAYS];
    logic [LINE_W-1:0] rd_line [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way #(
            .SETS   (SETS),
            .TAG_W  (PPN_W),
            .LINE_W (LINE_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (va_idx),
            .rd_valid  (rd_valid[w]),
            .rd_tag    (rd_tag[w]),
            .rd_line   (rd_line[w]),
            .fill_we   (line_fill_valid && (line_fill_way == WAY_W'(w))),
            .fill_idx  (line_fill_set),
            .fill_tag  (line_fill_tag),
            .fill_line (line_fill_data)
        );
        assign way_hit[w] = rd_valid[w] && (rd_tag[w] == tlb_ppn);
    end

    // Way select, lowest way first.
    logic [WAY_W-1:0]  sel_way;
    logic [LINE_W-1:0] sel_line;

    always_comb begin
        sel_way  = '0;
        sel_line = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                sel_way  = WAY_W'(w);
                sel_line = rd_line[w];
            end
        end
    end

    // Next response.
    outcome_e outcome;
    rsp_t     rsp_d, rsp_q;

    always_comb begin
        if (!req_valid)    outcome = OUT_NONE;
        else if (!tlb_hit) outcome = OUT_TLBMISS;
        else if (|way_hit) outcome = OUT_HIT;
        else               outcome = OUT_MISS;

        rsp_d       = '0;
        rsp_d.valid = (outcome != OUT_NONE);
        rsp_d.hit   = (outcome == OUT_HIT);
        rsp_d.miss  = (outcome == OUT_MISS);
        rsp_d.tlbm  = (outcome == OUT_TLBMISS);
        if (outcome == OUT_HIT) begin
            rsp_d.way  = sel_way;
            rsp_d.data = sel_line[va_wsel * WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_tlb_miss = rsp_q.tlbm;
    assign rsp_way      = rsp_q.way;
    assign rsp_data     = rsp_q.data;

    // R2: one response per request, one cycle later.
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3: missing translation gives a translation miss.
    a_r3_tlb_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tlb_hit) |=> (rsp_tlb_miss && !rsp_hit));
    // R4: a hit needs a translation hit in the request cycle.
    a_r4_hit_needs_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(tlb_hit));
    // R10: outcome flags are exclusive.
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_tlb_miss}));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_tlb_miss} == 3'b000));

endmodule

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;

    localparam int K_NONE = 0, K_HIT = 1, K_MISS = 2, K_TLBM = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_va = '0;
    logic         tlb_fill_valid = 1'b0;
    logic [1:0]   tlb_fill_slot = '0;
    logic [19:0]  tlb_fill_vpn = '0;
    logic [19:0]  tlb_fill_ppn = '0;
    logic         line_fill_valid = 1'b0;
    logic         line_fill_way = 1'b0;
    logic [5:0]   line_fill_set = '0;
    logic [19:0]  line_fill_tag = '0;
    logic [511:0] line_fill_data = '0;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_way;
    logic [31:0]  rsp_data;

    vipt_lookup dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_slot(tlb_fill_slot),
        .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
        .line_fill_valid(line_fill_valid), .line_fill_way(line_fill_way),
        .line_fill_set(line_fill_set), .line_fill_tag(line_fill_tag),
        .line_fill_data(line_fill_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_tlb_miss(rsp_tlb_miss), .rsp_way(rsp_way),
        .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // Fill requests staged for the next issued cycle.
    logic         nt_v = 1'b0;
    logic [1:0]   nt_slot;
    logic [19:0]  nt_vpn, nt_ppn;
    logic         nl_v = 1'b0;
    logic         nl_way;
    logic [5:0]   nl_set;
    logic [19:0]  nl_tag;
    logic [511:0] nl_data;

    // Expectation for the request in flight.
    int           pk = K_NONE;
    logic         pway = 1'b0;
    logic [31:0]  pdata = '0;
    string        ptag = "R2";

    function automatic logic [31:0] word_of(input int way, input int set, input int k,
                                            input logic [31:0] salt);
        return (32'h5A5A0000 ^ salt) | 32'((way << 12) | (set << 4) | k);
    endfunction

    function automatic logic [511:0] line_of(input int way, input int set,
                                             input logic [31:0] salt);
        logic [511:0] l;
        for (int k = 0; k < 16; k++) l[k*32 +: 32] = word_of(way, set, k, salt);
        return l;
    endfunction

    task automatic check_pending();
        logic [2:0] flags, eflags;
        flags = {rsp_hit, rsp_miss, rsp_tlb_miss};
        case (pk)
            K_HIT:   eflags = 3'b100;
            K_MISS:  eflags = 3'b010;
            K_TLBM:  eflags = 3'b001;
            default: eflags = 3'b000;
        endcase
        total++;
        if (rsp_valid !== (pk != K_NONE) || flags !== eflags) begin
            bad++;
            $display("FAIL %s: valid/hit/miss/tlbmiss=%b%b actual, %b%b expected",
                     ptag, rsp_valid, flags, (pk != K_NONE), eflags);
        end
        if (pk == K_HIT) begin
            total++;
            if (rsp_way !== pway || rsp_data !== pdata) begin
                bad++;
                $display("FAIL %s: way/data=%0d/%h actual, %0d/%h expected",
                         ptag, rsp_way, rsp_data, pway, pdata);
            end
        end
    endtask

    // One cycle: check the previous response, then drive request and staged fills.
    task automatic issue(input logic v, input logic [31:0] va, input int kind,
                         input logic way, input logic [31:0] data, input string tag);
        @(negedge clk);
        check_pending();
        req_valid       = v;
        req_va          = va;
        tlb_fill_valid  = nt_v;
        tlb_fill_slot   = nt_slot;
        tlb_fill_vpn    = nt_vpn;
        tlb_fill_ppn    = nt_ppn;
        line_fill_valid = nl_v;
        line_fill_way   = nl_way;
        line_fill_set   = nl_set;
        line_fill_tag   = nl_tag;
        line_fill_data  = nl_data;
        nt_v = 1'b0;
        nl_v = 1'b0;
        pk    = v ? kind : K_NONE;
        pway  = way;
        pdata = data;
        ptag  = v ? tag : "R2";
    endtask

    function automatic logic [31:0] mk_va(input logic [19:0] vpn, input int set, input int k);
        return {vpn, 6'(set), 4'(k), 2'b00};
    endfunction

    task automatic stage_tlb(input int slot, input logic [19:0] vpn, input logic [19:0] ppn);
        nt_v = 1'b1; nt_slot = 2'(slot); nt_vpn = vpn; nt_ppn = ppn;
    endtask

    task automatic stage_line(input int way, input int set, input logic [19:0] tag,
                              input logic [31:0] salt);
        nl_v = 1'b1; nl_way = 1'(way); nl_set = 6'(set); nl_tag = tag;
        nl_data = line_of(way, set, salt);
    endtask

    localparam logic [19:0] V0 = 20'h10000, V1 = 20'h20000, V2 = 20'h30000;
    localparam logic [19:0] V3 = 20'h40000, V4 = 20'h60000, VX = 20'h55555;
    localparam logic [19:0] PA = 20'h0A000, PB = 20'h0B000, PC = 20'h0C000;

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, no response.
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: rsp_valid=%b actual, 0 expected", rsp_valid);
        end
        rst_n = 1'b1;

        // R1: empty translation buffer, then empty lines.
        issue(1, mk_va(V0, 0, 0), K_TLBM, 0, 0, "R1");
        stage_tlb(0, V0, PA);
        issue(0, 0, K_NONE, 0, 0, "R2");
        issue(1, mk_va(V0, 0, 0), K_MISS, 0, 0, "R1");
        stage_tlb(1, V1, PB);
        issue(0, 0, K_NONE, 0, 0, "R2");
        stage_tlb(2, V2, PA);
        issue(0, 0, K_NONE, 0, 0, "R2");
        stage_tlb(3, V3, PC);
        issue(0, 0, K_NONE, 0, 0, "R2");

        // R8: fill every set of both ways.
        for (int s = 0; s < 64; s++) begin
            stage_line(0, s, PA, 32'h0);
            issue(0, 0, K_NONE, 0, 0, "R8");
            stage_line(1, s, PB, 32'h0);
            issue(0, 0, K_NONE, 0, 0, "R8");
        end

        // R4 R5 R6 R3 R2: back-to-back sweep of all sets.
        for (int s = 0; s < 64; s++) begin
            int k = (s * 7) % 16;
            issue(1, mk_va(V0, s, k), K_HIT, 0, word_of(0, s, k, 0), "R4");
            issue(1, mk_va(V1, s, k), K_HIT, 1, word_of(1, s, k, 0), "R4");
            issue(1, mk_va(V2, s, 15 - k), K_HIT, 0, word_of(0, s, 15 - k, 0), "R6");
            issue(1, mk_va(V3, s, k), K_MISS, 0, 0, "R5");
            issue(1, mk_va(VX, s, k), K_TLBM, 0, 0, "R3");
        end

        // R9: refill of set 5 way 1 is not seen by the same-cycle lookup.
        stage_line(1, 5, PC, 32'hFFFF0000);
        issue(1, mk_va(V3, 5, 3), K_MISS, 0, 0, "R9");
        issue(1, mk_va(V3, 5, 3), K_HIT, 1, word_of(1, 5, 3, 32'hFFFF0000), "R8");
        issue(1, mk_va(V1, 5, 3), K_MISS, 0, 0, "R8");
        issue(1, mk_va(V0, 5, 9), K_HIT, 0, word_of(0, 5, 9, 0), "R8");

        // R7 R9: slot replacement, lookup in the fill cycle sees the old mapping.
        stage_tlb(3, V4, PA);
        issue(1, mk_va(V3, 5, 2), K_HIT, 1, word_of(1, 5, 2, 32'hFFFF0000), "R9");
        issue(1, mk_va(V3, 3, 2), K_TLBM, 0, 0, "R7");
        issue(1, mk_va(V4, 3, 2), K_HIT, 0, word_of(0, 3, 2, 0), "R7");
        issue(0, 0, K_NONE, 0, 0, "R2");
        issue(0, 0, K_NONE, 0, 0, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule